// File: doc/BRIEF.md
# Multi-Policy Fixed-Point Adder/Subtractor

This block adds or subtracts two signed fractional operands of WIDTH bits. Each operand is two's complement with the binary point just after the sign bit, so values lie in [-1, 1). A two-bit policy input selects one of four ways to handle word growth and overflow: clamp, halve, halve only when needed, or wrap modulo 2^WIDTH. A rounding input selects whether a bit dropped by halving is removed by truncation or by round-half-to-even.

Each accepted operation produces a result, a shift flag and an overflow flag. The shift flag tells the caller that the result is the true sum divided by two. An outside controller can add up these flags to keep a shared exponent for a block of samples. The overflow flag marks a clamp, a wrap, or a rounding step that had to saturate.

The result sits in a single register stage that loads only on a valid input. The output valid flag follows the input valid flag one cycle later. The parameter SCALE_WIDE selects the width of the halving policy's output. At 0, the default, the result is WIDTH bits and is rounded. At 1, the result is WIDTH+1 bits and holds the exact sum.

Top module: `fxp_addsub_multi`

## Requirements
- R1: With mode_i = 0 (clamp), a sum that fits in WIDTH bits appears unchanged. A sum above the range gives 0111..1 and a sum below it gives 1000..0, with ovf_o = 1 and shift_o = 0 in both cases. No rounding is applied.
- R2: With mode_i = 1 (halve) and SCALE_WIDE = 0, the result is the exact sum S shifted right by one bit, and shift_o = 1. With round_i = 0 the dropped bit is discarded, which gives floor(S/2). With round_i = 1 and both the dropped bit and the kept LSB equal to 1, one LSB is added (round half to even).
- R3: When rounding up would carry the kept value past the most positive code, the result is 0111..1 and ovf_o = 1. Otherwise ovf_o = 0 in the halve and the conditional-halve modes.
- R4: With mode_i = 2 (conditional halve), a sum that fits in WIDTH bits is passed through unchanged with shift_o = 0.
- R5: With mode_i = 2, a sum that does not fit in WIDTH bits is halved and rounded as in R2 and R3, with shift_o = 1.
- R6: With mode_i = 3 (wrap), the result is the sum modulo 2^WIDTH, with shift_o = 0. ovf_o = 1 exactly when the true sum was outside the WIDTH-bit range.
- R7: With sub_i = 1 the block computes a_i - b_i exactly, including when b_i is the most negative value. With sub_i = 0 it computes a_i + b_i.
- R8: valid_o equals valid_i delayed by one cycle. While valid_i = 0, res_o, shift_o and ovf_o hold their previous values.
- R9: During and after reset, all outputs are zero until the first valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid, result register loads |
| a_i | input | WIDTH | First operand, signed fraction |
| b_i | input | WIDTH | Second operand, signed fraction |
| sub_i | input | 1 | 1 = a_i - b_i, 0 = a_i + b_i |
| mode_i | input | 2 | 0 clamp, 1 halve, 2 conditional halve, 3 wrap |
| round_i | input | 1 | 1 = round half to even, 0 = truncate |
| valid_o | output | 1 | Result valid |
| res_o | output | WIDTH+SCALE_WIDE | Registered result |
| shift_o | output | 1 | Result is the sum divided by two |
| ovf_o | output | 1 | Clamp, wrap or rounding saturation occurred |

## Verification
Directed sums drive each policy past the positive and the negative limit. This separates the clamp, wrap and halve policies from one another on the same operands. Odd sums such as 1, 3 and -1, taken with and without rounding, distinguish truncation, which floors, from half-to-even rounding, which rounds toward the even neighbour. Subtracting the most negative value from the most positive value reaches the rounding-saturation corner. Subtracting the most negative value from zero checks that the negated operand is carried exactly. A long seeded random stream covers all modes, both operations and both rounding settings, and is interleaved with idle cycles that must leave the result register untouched.

// File: rtl/fxp_add_pkg.sv
package fxp_add_pkg;
  typedef enum logic [1:0] {
    MODE_SAT   = 2'd0,
    MODE_SCALE = 2'd1,
    MODE_BFP   = 2'd2,
    MODE_WRAP  = 2'd3
  } add_mode_e;
endpackage

// File: rtl/fxp_presum.sv
module fxp_presum #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH:0]   sum_o,
  output logic             ovf_o
);
  logic [WIDTH:0] a_x, b_x, b_c;

  assign a_x = {a_i[WIDTH-1], a_i};
  assign b_x = {b_i[WIDTH-1], b_i};
  // negate in WIDTH+1 bits so that -(-1) is exact
  assign b_c = sub_i ? ~b_x : b_x;
  assign sum_o = a_x + b_c + {{WIDTH{1'b0}}, sub_i};
  assign ovf_o = sum_o[WIDTH] ^ sum_o[WIDTH-1];
endmodule

// File: rtl/fxp_halve.sv
module fxp_halve #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   sum_i,
  input  logic             round_i,
  output logic [WIDTH-1:0] q_o,
  output logic             sat_o
);
  localparam logic [WIDTH-1:0] MaxPos = {1'b0, {(WIDTH-1){1'b1}}};

  logic [WIDTH-1:0] kept;
  logic             bump;

  assign kept  = sum_i[WIDTH:1];
  // half-to-even: one dropped bit, bump only toward an even kept value
  assign bump  = round_i & sum_i[0] & kept[0];
  assign sat_o = bump & (kept == MaxPos);
  assign q_o   = sat_o ? MaxPos : kept + {{(WIDTH-1){1'b0}}, bump};
endmodule

// File: rtl/fxp_policy.sv
module fxp_policy
  import fxp_add_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit SCALE_WIDE = 1'b0,
  localparam int OutW      = WIDTH + int'(SCALE_WIDE)
) (
  input  logic [WIDTH:0]   sum_i,
  input  logic             ovf_i,
  input  logic [WIDTH-1:0] half_i,
  input  logic             half_sat_i,
  input  logic [1:0]       mode_i,
  output logic [OutW-1:0]  res_o,
  output logic             shift_o,
  output logic             flag_o
);
  localparam logic [WIDTH-1:0] MaxPos = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MaxNeg = {1'b1, {(WIDTH-1){1'b0}}};

  add_mode_e        mode;
  logic [WIDTH-1:0] nres;
  logic             nshift, nflag;

  assign mode = add_mode_e'(mode_i);

  always_comb begin
    nres   = sum_i[WIDTH-1:0];
    nshift = 1'b0;
    nflag  = 1'b0;
    unique case (mode)
      MODE_SAT: begin
        nflag = ovf_i;
        if (ovf_i) nres = sum_i[WIDTH] ? MaxNeg : MaxPos;
      end
      MODE_SCALE: begin
        nres   = half_i;
        nshift = 1'b1;
        nflag  = half_sat_i;
      end
      MODE_BFP: begin
        if (ovf_i) begin
          nres   = half_i;
          nshift = 1'b1;
          nflag  = half_sat_i;
        end
      end
      MODE_WRAP: nflag = ovf_i;
      default: ;
    endcase
  end

  generate
    if (SCALE_WIDE) begin : g_wide
      assign res_o   = (mode == MODE_SCALE) ? sum_i : {nres[WIDTH-1], nres};
      assign flag_o  = (mode == MODE_SCALE) ? 1'b0 : nflag;
      assign shift_o = nshift;
    end else begin : g_narrow
      assign res_o   = nres;
      assign flag_o  = nflag;
      assign shift_o = nshift;
    end
  endgenerate
endmodule

// File: rtl/fxp_addsub_multi.sv
module fxp_addsub_multi #(
  parameter int WIDTH      = 8,
  parameter bit SCALE_WIDE = 1'b0,
  localparam int OutW      = WIDTH + int'(SCALE_WIDE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic [1:0]       mode_i,
  input  logic             round_i,
  output logic             valid_o,
  output logic [OutW-1:0]  res_o,
  output logic             shift_o,
  output logic             ovf_o
);
  logic [WIDTH:0]   sum;
  logic             sum_ovf;
  logic [WIDTH-1:0] half;
  logic             half_sat;
  logic [OutW-1:0]  res_d;
  logic             shift_d, flag_d;

  fxp_presum #(.WIDTH(WIDTH)) i_presum (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_i),
    .sum_o (sum),
    .ovf_o (sum_ovf)
  );

  fxp_halve #(.WIDTH(WIDTH)) i_halve (
    .sum_i   (sum),
    .round_i (round_i),
    .q_o     (half),
    .sat_o   (half_sat)
  );

  fxp_policy #(.WIDTH(WIDTH), .SCALE_WIDE(SCALE_WIDE)) i_policy (
    .sum_i      (sum),
    .ovf_i      (sum_ovf),
    .half_i     (half),
    .half_sat_i (half_sat),
    .mode_i     (mode_i),
    .res_o      (res_d),
    .shift_o    (shift_d),
    .flag_o     (flag_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      shift_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= res_d;
        shift_o <= shift_d;
        ovf_o   <= flag_d;
      end
    end
  end
endmodule

// File: rtl/fxp_addsub_chk.sv
module fxp_addsub_chk #(
  parameter int WIDTH      = 8,
  parameter bit SCALE_WIDE = 1'b0,
  localparam int OutW      = WIDTH + int'(SCALE_WIDE)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       mode_i,
  input logic             valid_o,
  input logic [OutW-1:0]  res_o,
  input logic             shift_o,
  input logic             ovf_o
);
  localparam logic [WIDTH-1:0] MaxPos = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MaxNeg = {1'b1, {(WIDTH-1){1'b0}}};

  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R8
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(shift_o) && $stable(ovf_o)));
  // R1
  sat_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd0) |=>
      (!shift_o && (!ovf_o || res_o[WIDTH-1:0] == MaxPos || res_o[WIDTH-1:0] == MaxNeg)));
  // R2
  scale_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd1) |=> shift_o);
  // R6
  wrap_noshift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd3) |=> !shift_o);
  // R5
  bfp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2) |=> (!ovf_o || shift_o));
endmodule

bind fxp_addsub_multi fxp_addsub_chk #(.WIDTH(WIDTH), .SCALE_WIDE(SCALE_WIDE)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .valid_o (valid_o),
  .res_o   (res_o),
  .shift_o (shift_o),
  .ovf_o   (ovf_o)
);

// File: tb/test_fxp_addsub_multi.sv
module test_fxp_addsub_multi;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         sub_i = 1'b0, round_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic         valid_o, shift_o, ovf_o;
  logic [W-1:0] res_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  fxp_addsub_multi #(.WIDTH(W)) i_fxp_addsub_multi (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .sub_i, .mode_i, .round_i,
    .valid_o, .res_o, .shift_o, .ovf_o
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference from the requirements
  function automatic void model(int a, int b, bit sub, int mode, bit rnd,
                                output int r, output bit sh, output bit ov);
    int s, h, hi, lo;
    bit fits;
    hi = (1 << (W-1)) - 1;
    lo = -(1 << (W-1));
    s = sub ? a - b : a + b;
    fits = (s <= hi) && (s >= lo);
    h = s >>> 1;
    sh = 0; ov = 0; r = s;
    if ((mode == 1) || (mode == 2 && !fits)) begin
      sh = 1;
      if (rnd && (s & 1) != 0 && (h & 1) != 0) h = h + 1;
      if (h > hi) begin h = hi; ov = 1; end
      r = h;
    end else if (mode == 0) begin
      ov = !fits;
      r = (s > hi) ? hi : (s < lo) ? lo : s;
    end else if (mode == 3) begin
      ov = !fits;
      r = s & ((1 << W) - 1);
      if (r > hi) r = r - (1 << W);
    end
  endfunction

  task automatic op(string req, int a, int b, bit sub, int mode, bit rnd);
    int er; bit es, eo;
    a_i = W'(a); b_i = W'(b); sub_i = sub; mode_i = 2'(mode); round_i = rnd;
    valid_i = 1'b1;
    @(negedge clk_i);
    model($signed(W'(a)), $signed(W'(b)), sub, mode, rnd, er, es, eo);
    chk({req, " res"}, int'($signed(res_o)), er);
    chk({req, " shift"}, int'(shift_o), int'(es));
    chk({req, " ovf"}, int'(ovf_o), int'(eo));
    chk({req, " R8 valid"}, int'(valid_o), 1);
  endtask

  task automatic idle(int a, int b);
    int r0, s0, o0;
    r0 = int'($signed(res_o)); s0 = int'(shift_o); o0 = int'(ovf_o);
    valid_i = 1'b0; a_i = W'(a); b_i = W'(b); mode_i = 2'(a & 3);
    @(negedge clk_i);
    chk("R8 hold res", int'($signed(res_o)), r0);
    chk("R8 hold shift", int'(shift_o), s0);
    chk("R8 hold ovf", int'(ovf_o), o0);
    chk("R8 valid low", int'(valid_o), 0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    chk("R9 reset valid", int'(valid_o), 0);
    chk("R9 reset res", int'(res_o), 0);
    chk("R9 reset flags", int'({shift_o, ovf_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 post-reset res", int'(res_o), 0);

    op("R1 pos clamp", 100, 100, 0, 0, 1);
    op("R1 neg clamp", -100, -100, 0, 0, 0);
    op("R1 in range", 20, -50, 0, 0, 1);
    op("R2 trunc 3", 3, 0, 0, 1, 0);
    op("R2 round 3", 3, 0, 0, 1, 1);
    op("R2 round 1 even", 1, 0, 0, 1, 1);
    op("R2 trunc -1", -1, 0, 0, 1, 0);
    op("R2 round -1", -1, 0, 0, 1, 1);
    op("R3 round sat", 127, -128, 1, 1, 1);
    op("R3 trunc no sat", 127, -128, 1, 1, 0);
    op("R4 fits", 50, 20, 0, 2, 1);
    op("R5 grows", 100, 100, 0, 2, 0);
    op("R5 round sat", 127, -128, 1, 2, 1);
    op("R5 neg grows", -128, 1, 1, 2, 1);
    op("R6 wrap pos", 100, 100, 0, 3, 0);
    op("R6 wrap neg", -128, -1, 0, 3, 0);
    op("R7 minus min", 0, -128, 1, 0, 0);
    op("R7 min minus min", -128, -128, 1, 3, 0);
    idle(77, -3);

    for (int i = 0; i < 600; i++) begin
      int a, b;
      a = int'($urandom()) % 256 - 128;
      b = int'($urandom()) % 256 - 128;
      if ((i % 37) == 0) a = 127;
      if ((i % 41) == 0) b = -128;
      op("R7 random", a, b, 1'($urandom()), int'($urandom() % 4), 1'($urandom()));
      if (($urandom() % 8) == 0) idle(a, b);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule